// File: doc/BRIEF.md
# Idle-Aware Clock Gating Controller

This block decides, for a small group of peripheral clocks, whether each clock enable is on or off. Software writes a hint vector with one bit per clock. Each unit sends an idle indication as a 4-bit multi-bit boolean. A hint of 1 keeps a clock running, or starts it again. A hint of 0 only asks for the clock to stop. The clock is stopped once its unit has reported idle without a break for a programmed number of cycles.

The status vector shows which clocks are actually running. The clock-enable outputs follow the status vector, and they stand in for the clock-gate cells. Once a lock bit is set, the hint register accepts no more writes until reset.

Each unit's idle-wait counter is stored twice: a primary copy and its bitwise inverse. A mismatch between the copies sets a sticky bit for that unit in a fatal error code and raises a fatal alert. A fault-injection input can corrupt the inverse copy so that this path can be exercised.

Top module: `idle_clock_gater`

## Requirements
- R1: After reset, every hint, status and clock-enable bit is 1, the fatal error code is all zero, the fatal alert is low and the lock is clear.
- R2: An idle input counts as idle only when it equals exactly 4'h6. Every other code, including 4'h9 (false), counts as busy and leaves a clock with hint 0 running.
- R3: With hint 0 and status 1, the status bit falls on the edge where idle has been sampled true on N consecutive edges. N is `idle_thresh`, or 1 when `idle_thresh` is 0. A single busy sample resets the count to zero.
- R4: A hint bit that is 1 sets its status bit to 1 on the next edge, whatever the idle input holds.
- R5: Each `clk_en_o` bit equals its status bit, so a status of 0 means the clock enable is off.
- R6: `cfg_wr` loads `cfg_hint` into the hint register on the next edge, unless the lock is set. A `lock_set` pulse sets the lock, and the lock stays set until reset. Writes made while locked have no effect.
- R7: When a unit's two counter copies disagree, bit i of `fatal_code_o` is set on the following edge. The bit stays set until reset, and `fatal_alert_o` is the OR of all fatal code bits. A `fault_inj[i]` pulse flips the stored inverse copy of unit i on that edge.
- R8: Units are independent: the hint and idle input of one unit never change the status of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Hint register write strobe |
| cfg_hint | input | NUM_CLK | Hint value to write |
| lock_set | input | 1 | Sets the configuration lock |
| idle_thresh | input | CNT_W | Consecutive idle cycles needed before gating |
| idle_mubi | input | 4*NUM_CLK | Per-unit idle, 4-bit multi-bit boolean |
| fault_inj | input | NUM_CLK | Flips the inverse counter copy of a unit |
| hint_o | output | NUM_CLK | Current hint register |
| status_o | output | NUM_CLK | Clock running status |
| clk_en_o | output | NUM_CLK | Clock enable per unit |
| fatal_code_o | output | NUM_CLK | Sticky idle-counter fault bits |
| fatal_alert_o | output | 1 | Fatal alert |

## Verification
The in-line assertions run on every cycle and check several rules. A status bit may fall only after an idle-true, hint-0 sample. A busy sample or a hint of 1 keeps the status high on the next edge. A lock freezes the hint register, and fault bits never clear. The bench scenarios are needed for the rest. They check the exact edge on which gating lands for each threshold, and that the count restarts after a busy sample. They sweep all sixteen idle codes and confirm the strict-true rule. They also show that an injected copy mismatch reaches the error code.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
    typedef logic [3:0] mubi4_t;

    localparam mubi4_t MUBI4_TRUE  = 4'h6;
    localparam mubi4_t MUBI4_FALSE = 4'h9;

    typedef enum logic [1:0] {
        GATE_RUN  = 2'd0,
        GATE_WAIT = 2'd1,
        GATE_OFF  = 2'd2
    } gate_phase_e;

    function automatic logic mubi4_true_strict(mubi4_t v);
        return v == MUBI4_TRUE;
    endfunction
endpackage

// File: rtl/redun_idle_cnt.sv
module redun_idle_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic             inj,
    output logic [CNT_W-1:0] cnt,
    output logic             mismatch
);
    logic [CNT_W-1:0] prim_q, inv_q, nxt;

    always_comb begin
        nxt = prim_q;
        if (clr)      nxt = '0;
        else if (inc) nxt = prim_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= '0;
            inv_q  <= '1;
        end else begin
            prim_q <= nxt;
            inv_q  <= ~nxt ^ {{(CNT_W-1){1'b0}}, inj};
        end
    end

    assign cnt      = prim_q;
    assign mismatch = (prim_q != ~inv_q);
endmodule

// File: rtl/unit_gate.sv
module unit_gate
    import clkgate_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hint,
    input  mubi4_t           idle,
    input  logic [CNT_W-1:0] thresh,
    input  logic             inj,
    output logic             status,
    output logic             cnt_err
);
    logic             idle_true;
    logic             status_q;
    logic             clr, inc, reach;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] thr_eff;
    gate_phase_e      phase;

    assign idle_true = mubi4_true_strict(idle);
    assign thr_eff   = (thresh == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : thresh;
    assign reach     = ({1'b0, cnt} + 1'b1) >= {1'b0, thr_eff};

    always_comb begin
        if (hint)          phase = GATE_RUN;
        else if (status_q) phase = GATE_WAIT;
        else               phase = GATE_OFF;
    end

    always_comb begin
        clr = 1'b1;
        inc = 1'b0;
        if (phase == GATE_WAIT && idle_true && !reach) begin
            clr = 1'b0;
            inc = 1'b1;
        end
    end

    redun_idle_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr), .inc(inc), .inj(inj),
        .cnt(cnt), .mismatch(cnt_err)
    );

    always_ff @(posedge clk) begin
        if (rst)                                      status_q <= 1'b1;
        else if (phase == GATE_RUN)                   status_q <= 1'b1;
        else if (phase == GATE_WAIT && idle_true && reach) status_q <= 1'b0;
    end

    assign status = status_q;

    // R2
    status_fall_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(status_q) |-> ($past(idle_true) && !$past(hint)));
    // R3
    busy_keeps_run_chk: assert property (@(posedge clk) disable iff (rst)
        (!idle_true && status_q) |=> status_q);
    // R4
    hint_reenable_chk: assert property (@(posedge clk) disable iff (rst)
        hint |=> status_q);
endmodule

// File: rtl/idle_clock_gater.sv
module idle_clock_gater
    import clkgate_pkg::*;
#(
    parameter int NUM_CLK = 4,
    parameter int CNT_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [NUM_CLK-1:0]   cfg_hint,
    input  logic                 lock_set,
    input  logic [CNT_W-1:0]     idle_thresh,
    input  logic [4*NUM_CLK-1:0] idle_mubi,
    input  logic [NUM_CLK-1:0]   fault_inj,
    output logic [NUM_CLK-1:0]   hint_o,
    output logic [NUM_CLK-1:0]   status_o,
    output logic [NUM_CLK-1:0]   clk_en_o,
    output logic [NUM_CLK-1:0]   fatal_code_o,
    output logic                 fatal_alert_o
);
    logic [NUM_CLK-1:0] hint_q, stat, cerr, code_q;
    logic               lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hint_q <= '1;
            lock_q <= 1'b0;
            code_q <= '0;
        end else begin
            if (cfg_wr && !lock_q) hint_q <= cfg_hint;
            if (lock_set)          lock_q <= 1'b1;
            code_q <= code_q | cerr;
        end
    end

    for (genvar i = 0; i < NUM_CLK; i++) begin : g_unit
        unit_gate #(.CNT_W(CNT_W)) u_gate (
            .clk(clk), .rst(rst), .hint(hint_q[i]),
            .idle(idle_mubi[4*i +: 4]), .thresh(idle_thresh),
            .inj(fault_inj[i]), .status(stat[i]), .cnt_err(cerr[i])
        );
    end

    assign hint_o        = hint_q;
    assign status_o      = stat;
    assign clk_en_o      = stat;
    assign fatal_code_o  = code_q;
    assign fatal_alert_o = |code_q;

    // R6
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> $stable(hint_q));
    // R7
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (|code_q) |=> ((code_q & $past(code_q)) == $past(code_q)));
    // R7
    mismatch_report_chk: assert property (@(posedge clk) disable iff (rst)
        (|cerr) |=> ((code_q & $past(cerr)) == $past(cerr)));
endmodule

// File: tb/sim_idle_clock_gater.sv
module sim_idle_clock_gater;
    localparam int N  = 4;
    localparam int CW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_wr = 1'b0;
    logic [N-1:0]    cfg_hint = '1;
    logic            lock_set = 1'b0;
    logic [CW-1:0]   idle_thresh = 4'd2;
    logic [4*N-1:0]  idle_mubi = {N{4'h9}};
    logic [N-1:0]    fault_inj = '0;
    logic [N-1:0]    hint_o, status_o, clk_en_o, fatal_code_o;
    logic            fatal_alert_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    idle_clock_gater #(.NUM_CLK(N), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_hint(cfg_hint),
        .lock_set(lock_set), .idle_thresh(idle_thresh), .idle_mubi(idle_mubi),
        .fault_inj(fault_inj), .hint_o(hint_o), .status_o(status_o),
        .clk_en_o(clk_en_o), .fatal_code_o(fatal_code_o),
        .fatal_alert_o(fatal_alert_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write_hint(logic [N-1:0] v);
        cfg_hint = v;
        cfg_wr   = 1'b1;
        step(1);
        cfg_wr   = 1'b0;
    endtask

    initial begin
        step(2);
        rst = 1'b0;
        // R1
        chk("R1 hint", hint_o, 4'hF);
        chk("R1 status", status_o, 4'hF);
        chk("R1 clk_en", clk_en_o, 4'hF);
        chk("R1 fatal", {fatal_alert_o, fatal_code_o}, 0);

        // R2: sweep all idle codes on unit 0, threshold 2
        idle_thresh = 4'd2;
        for (int code = 0; code < 16; code++) begin
            idle_mubi[3:0] = code[3:0];
            write_hint(4'b1110);
            step(4);
            chk("R2 strict idle", status_o[0], (code == 6) ? 1'b0 : 1'b1);
            // R5
            chk("R5 clk_en follows status", clk_en_o, status_o);
            // R8
            chk("R8 other units", status_o[3:1], 3'b111);
            write_hint(4'hF);
            step(1);
        end

        // R3: exact gating edge for each threshold, 0 meaning 1
        idle_mubi[3:0] = 4'h6;
        for (int t = 0; t < 6; t++) begin
            int eff;
            eff = (t == 0) ? 1 : t;
            idle_thresh = t[CW-1:0];
            write_hint(4'b1110);
            for (int k = 1; k <= eff; k++) begin
                step(1);
                chk("R3 gate edge", status_o[0], (k < eff) ? 1'b1 : 1'b0);
            end
            // R4: re-enable while idle is still true
            write_hint(4'hF);
            chk("R4 not yet", status_o[0], 1'b0);
            step(1);
            chk("R4 reenabled", status_o[0], 1'b1);
            chk("R5 clk_en on", clk_en_o[0], 1'b1);
        end

        // R3: busy sample restarts count
        idle_thresh = 4'd4;
        write_hint(4'b1110);
        step(2);
        idle_mubi[3:0] = 4'h9;
        step(1);
        idle_mubi[3:0] = 4'h6;
        step(3);
        chk("R3 restart held", status_o[0], 1'b1);
        step(1);
        chk("R3 restart gated", status_o[0], 1'b0);
        chk("R5 clk_en off", clk_en_o[0], 1'b0);

        // R8: two units gating with separate idle inputs
        idle_thresh = 4'd1;
        idle_mubi[11:8] = 4'h6;
        write_hint(4'b1010);
        step(1);
        chk("R8 per-unit status", status_o, 4'b1010);
        write_hint(4'hF);
        step(1);
        chk("R4 all running", status_o, 4'hF);

        // R7: fault injection on unit 2
        fault_inj = 4'b0100;
        step(1);
        fault_inj = '0;
        step(1);
        chk("R7 code", fatal_code_o, 4'b0100);
        chk("R7 alert", fatal_alert_o, 1'b1);
        step(5);
        chk("R7 sticky", fatal_code_o, 4'b0100);

        // R6: lock blocks writes
        lock_set = 1'b1;
        step(1);
        lock_set = 1'b0;
        write_hint(4'b0000);
        step(2);
        chk("R6 locked hint", hint_o, 4'hF);
        chk("R6 locked status", status_o, 4'hF);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule